// File: doc/BRIEF.md
# EPROM Boot Loader

After reset this block copies a program image out of a byte-wide external EPROM into internal memory, so that the core can start running code it does not yet hold. It samples the boot-mode strap once. A low strap selects EPROM boot, and the block then reads a fixed block of bytes over a simple asynchronous bus. It drives a dedicated active-low chip select, a byte address and an active-low read strobe, and it holds the strobe low for a fixed wait time on every byte.

The block gathers each group of four bytes into one 32-bit instruction word, least significant byte first. It writes each word to internal memory, starting at word address 0. When the last word has been written, the block gives a single-cycle done pulse and releases the chip select. The core uses that pulse as the interrupt that takes it out of its post-reset idle state. A high strap leaves the block parked, with the bus quiet.

Top module: `eprom_boot_loader`

## Requirements
- R1: While rst_n is low (asynchronous, active low) the outputs are idle: romCs_n=1, romRd_n=1, memWe=0, bootDone=0. An assertion of rst_n in the middle of a load abandons the load, and the next load starts again from byte 0.
- R2: bootStrap is sampled on the first rising clock edge after rst_n goes high. A value of 0 starts loading in the next cycle. Any later change on bootStrap has no effect.
- R3: If bootStrap is 1 when it is sampled, the block stays parked until the next reset: romCs_n and romRd_n stay 1, memWe and bootDone stay 0.
- R4: Each byte read holds romRd_n low for exactly WAIT_CYCLES (default 16) consecutive cycles. romData is captured on the clock edge that ends the last of those cycles. Exactly one cycle with romRd_n high follows each read.
- R5: romAddr (24 bits) is 0 for the first read and rises by one for each later read. It is stable while romRd_n is low.
- R6: Bytes are packed little-endian: the byte from address 4k goes to memData[7:0], 4k+1 to [15:8], 4k+2 to [23:16] and 4k+3 to [31:24].
- R7: memWe is high for one cycle, in the cycle with romRd_n high that follows the fourth byte of each word, with memAddr=k. Exactly NUM_WORDS (default 256) writes happen, with k rising from 0 to NUM_WORDS-1.
- R8: In the cycle after the last write, bootDone is high for exactly one cycle with romCs_n=1. No further reads, writes or done pulses occur until reset.
- R9: romCs_n is low from the first read through the last write, and romRd_n is never low while romCs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bootStrap | input | 1 | Boot-mode strap, 0 selects EPROM boot |
| romData | input | 8 | Byte returned by the EPROM |
| romCs_n | output | 1 | EPROM chip select, active low |
| romRd_n | output | 1 | EPROM read strobe, active low |
| romAddr | output | 24 | EPROM byte address |
| memWe | output | 1 | Internal memory write enable |
| memAddr | output | 8 | Internal memory word address |
| memData | output | 32 | Packed instruction word |
| bootDone | output | 1 | One-cycle load-complete pulse |

## Verification
The hardest situation to reach from the ports is a capture made one cycle too early: the byte would still look plausible. To expose it, the EPROM model in the bench drives the bitwise complement of the correct byte until the strobe has been low for the full wait time. Any early capture then shows up as a wrong packed word. Strap changes after sampling and a reset in the middle of a load are driven in directed runs. Each image is seeded differently, so that byte order and address errors give distinct words.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef struct packed {
    logic clear;
    logic waitInc;
    logic capture;
    logic advance;
  } bootCtl_t;

  typedef struct packed {
    logic waitLast;
    logic laneLast;
    logic imageLast;
  } bootStat_t;

  typedef enum logic [2:0] {
    IDLE_S,
    STROBE_S,
    GAP_S,
    DONE_S,
    PARK_S,
    HALT_S
  } bootState_t;

endpackage

// File: rtl/boot_datapath.sv
module boot_datapath
  import boot_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_WORDS   = 256,
  parameter int WAIT_CYCLES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  bootCtl_t                     ctl,
  input  logic [7:0]                   romData,
  output bootStat_t                    status,
  output logic [ADDR_W-1:0]            romAddr,
  output logic [$clog2(NUM_WORDS)-1:0] memAddr,
  output logic [31:0]                  memData
);
  localparam int MEM_AW   = $clog2(NUM_WORDS);
  localparam int BYTE_CNT = NUM_WORDS * 4;
  localparam int WAIT_W   = $clog2(WAIT_CYCLES + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [31:0]       wordReg;
  logic [1:0]        lane;

  assign lane = romAddr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      romAddr <= '0;
      waitCnt <= '0;
      wordReg <= '0;
    end else begin
      if (ctl.clear) begin
        romAddr <= '0;
        waitCnt <= '0;
      end
      if (ctl.waitInc) waitCnt <= waitCnt + 1'b1;
      if (ctl.capture) begin
        wordReg[{lane, 3'b000} +: 8] <= romData;
        waitCnt <= '0;
      end
      if (ctl.advance) romAddr <= romAddr + 1'b1;
    end
  end

  assign status.waitLast  = (waitCnt == WAIT_W'(WAIT_CYCLES - 1));
  assign status.laneLast  = (lane == 2'd3);
  assign status.imageLast = (romAddr == ADDR_W'(BYTE_CNT - 1));
  assign memAddr          = romAddr[MEM_AW+1:2];
  assign memData          = wordReg;

  // R4
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waitCnt <= WAIT_W'(WAIT_CYCLES - 1));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.waitInc |=> $stable(romAddr));

endmodule

// File: rtl/boot_control.sv
module boot_control
  import boot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bootStrap,
  input  bootStat_t status,
  output bootCtl_t  ctl,
  output logic      romCs_n,
  output logic      romRd_n,
  output logic      memWe,
  output logic      bootDone
);
  bootState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= IDLE_S;
    else        state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    unique case (state)
      IDLE_S: begin
        ctl.clear = 1'b1;
        nextState = bootStrap ? PARK_S : STROBE_S;
      end
      STROBE_S: begin
        if (status.waitLast) begin
          ctl.capture = 1'b1;
          nextState   = GAP_S;
        end else begin
          ctl.waitInc = 1'b1;
        end
      end
      GAP_S: begin
        ctl.advance = 1'b1;
        nextState   = status.imageLast ? DONE_S : STROBE_S;
      end
      DONE_S:  nextState = HALT_S;
      PARK_S:  nextState = PARK_S;
      HALT_S:  nextState = HALT_S;
      default: nextState = HALT_S;
    endcase
  end

  assign romCs_n  = !((state == STROBE_S) || (state == GAP_S));
  assign romRd_n  = (state != STROBE_S);
  assign memWe    = (state == GAP_S) && status.laneLast;
  assign bootDone = (state == DONE_S);

  // R9
  rd_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !romRd_n |-> !romCs_n);

  // R7
  we_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (romRd_n && !romCs_n));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bootDone |=> (!bootDone && romCs_n));

  // R3
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PARK_S) |-> (romCs_n && !memWe && !bootDone));

  // R8
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bootDone |-> $past(memWe));

endmodule

// File: rtl/eprom_boot_loader.sv
module eprom_boot_loader
  import boot_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_WORDS   = 256,
  parameter int WAIT_CYCLES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bootStrap,
  input  logic [7:0]                   romData,
  output logic                         romCs_n,
  output logic                         romRd_n,
  output logic [ADDR_W-1:0]            romAddr,
  output logic                         memWe,
  output logic [$clog2(NUM_WORDS)-1:0] memAddr,
  output logic [31:0]                  memData,
  output logic                         bootDone
);
  bootCtl_t  ctl;
  bootStat_t status;

  boot_control u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bootStrap(bootStrap),
    .status   (status),
    .ctl      (ctl),
    .romCs_n  (romCs_n),
    .romRd_n  (romRd_n),
    .memWe    (memWe),
    .bootDone (bootDone)
  );

  boot_datapath #(
    .ADDR_W     (ADDR_W),
    .NUM_WORDS  (NUM_WORDS),
    .WAIT_CYCLES(WAIT_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .romData(romData),
    .status (status),
    .romAddr(romAddr),
    .memAddr(memAddr),
    .memData(memData)
  );

endmodule

// File: tb/sim_eprom_boot_loader.sv
module sim_eprom_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT       = 16;
  localparam int WORDS      = 256;
  localparam int LOAD_CYC   = WORDS * 4 * (WAIT + 1) + 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bootStrap = 1'b0;
  logic [7:0]  romData;
  logic        romCs_n, romRd_n, memWe, bootDone;
  logic [23:0] romAddr;
  logic [7:0]  memAddr;
  logic [31:0] memData;

  int   nChecks = 0;
  int   nFails  = 0;
  int   lowCnt = 0;
  int   byteCount = 0;
  int   wordCount = 0;
  int   doneCnt = 0;
  logic prevWe = 1'b0;
  logic [7:0] seed = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] romByte(input int a, input logic [7:0] s);
    logic [7:0] t;
    t = 8'(a * 29);
    return t ^ 8'(a >> 8) ^ s;
  endfunction

  function automatic logic [31:0] expWord(input int k, input logic [7:0] s);
    return {romByte(4*k+3, s), romByte(4*k+2, s), romByte(4*k+1, s), romByte(4*k, s)};
  endfunction

  assign romData = (lowCnt >= WAIT) ? romByte(int'(romAddr), seed)
                                    : ~romByte(int'(romAddr), seed);

  eprom_boot_loader u0 (
    .clk(clk), .rst_n(rst_n), .bootStrap(bootStrap), .romData(romData),
    .romCs_n(romCs_n), .romRd_n(romRd_n), .romAddr(romAddr),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .bootDone(bootDone)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor and EPROM access-time model
  always @(negedge clk) begin
    if (rst_n) begin
      if (!romRd_n) begin
        if (lowCnt == 0) begin
          check(romAddr == 24'(byteCount), "R5 read address", romAddr, byteCount);
          check(!romCs_n, "R9 cs during read", romCs_n, 0);
          byteCount++;
        end
        lowCnt++;
      end else begin
        if (lowCnt != 0)
          check(lowCnt == WAIT, "R4 strobe length", lowCnt, WAIT);
        lowCnt = 0;
      end
      if (memWe) begin
        check(memAddr == 8'(wordCount), "R7 write address", memAddr, wordCount);
        check(memData == expWord(wordCount, seed), "R6 packed word", memData,
              expWord(wordCount, seed));
        wordCount++;
      end
      if (bootDone) begin
        check(prevWe && wordCount == WORDS, "R8 done after last write", wordCount, WORDS);
        check(romCs_n, "R8 cs released at done", romCs_n, 1);
        doneCnt++;
      end
      prevWe = memWe;
    end
  end

  task automatic clearCounts();
    lowCnt = 0; byteCount = 0; wordCount = 0; doneCnt = 0; prevWe = 1'b0;
  endtask

  task automatic checkIdle(input string tag);
    check(romCs_n && romRd_n && !memWe && !bootDone, tag,
          {romCs_n, romRd_n, memWe, bootDone}, 4'b1100);
  endtask

  task automatic startRun(input logic strap, input logic [7:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    bootStrap = strap;
    seed = s;
    #1;
    checkIdle("R1 reset outputs");
    repeat (3) @(negedge clk);
    checkIdle("R1 reset outputs held");
    clearCounts();
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic       strap;
    logic [7:0] seed;
    logic       flip;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 8'h00, 1'b0},
    '{1'b0, 8'h5a, 1'b1},
    '{1'b1, 8'h00, 1'b0},
    '{1'b1, 8'h33, 1'b1}
  };

  initial begin
    repeat (2) @(negedge clk);
    foreach (VECS[i]) begin
      startRun(VECS[i].strap, VECS[i].seed);
      if (VECS[i].flip) begin
        repeat (3) @(negedge clk);
        bootStrap = ~bootStrap;  // R2: must be ignored
      end
      if (!VECS[i].strap) begin
        for (int c = 0; c < LOAD_CYC && doneCnt == 0; c++) @(negedge clk);
        repeat (60) @(negedge clk);
        check(wordCount == WORDS, "R7 word total", wordCount, WORDS);
        check(byteCount == WORDS*4, "R2 load ran", byteCount, WORDS*4);
        check(doneCnt == 1, "R8 single done", doneCnt, 1);
        check(romCs_n && romRd_n, "R8 bus quiet after done", {romCs_n, romRd_n}, 2'b11);
      end else begin
        repeat (2000) @(negedge clk);
        check(byteCount == 0 && wordCount == 0, "R3 no bus activity", byteCount, 0);
        check(doneCnt == 0, "R3 no done", doneCnt, 0);
        checkIdle("R3 parked outputs");
      end
    end

    // R1: reset in the middle of a load, then a clean reload from byte 0
    startRun(1'b0, 8'hc3);
    repeat (3000) @(negedge clk);
    check(wordCount > 0 && doneCnt == 0, "R1 load under way", wordCount, 1);
    rst_n = 1'b0;
    #1;
    checkIdle("R1 async reset mid-load");
    repeat (2) @(negedge clk);
    seed = 8'h81;
    clearCounts();
    rst_n = 1'b1;
    for (int c = 0; c < LOAD_CYC && doneCnt == 0; c++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(wordCount == WORDS && doneCnt == 1, "R1 reload complete", wordCount, WORDS);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule